// File: doc/BRIEF.md
# Routed Hardware Interrupt Controller

This block collects up to 32 level-sensitive hardware interrupt lines, records which of them are active, and turns the active ones into processor interrupt levels (1 to 15). A fixed table assigns each source line a level. Several lines may share one level, and some lines are never used. Software masks individual sources through a mask register. The register has one write word that sets mask bits and another that clears them. Its top bit acts as a global switch that shuts off all routed interrupts.

The result goes to exactly one processor at a time, chosen by a target register. The other processors see an all-zero level vector. Each processor also gets a status vector, which shows the levels of all active sources whether or not they are masked. Like the level vector, the status vector is delivered only to the target processor.

Software reaches the block through a 32-bit word port. A write strobe, a 3-bit word index and write data form a write. Reads are combinational on the addressed word. All state sits in flops, so every output changes on the clock edge that follows a write or a source change.

Top module: `irq_router`

## Requirements
- R1: After reset, the pending word reads 0, the mask word reads 0 (the stored mask is 0x0FA2007F), the target reads 0, every level and status vector is 0, and `master_off_o` is 0.
- R2: Word index 0 reads the pending set. The pending set equals the source lines sampled at the previous clock edge, ANDed with 0x787FFFFF. Lines 23 to 26 and line 31 always read 0.
- R3: A write to word index 2 clears the mask bits written as 1. A write to word index 3 sets them. Both writes apply only bits inside 0xF05DFF80, so the stored bits outside that set stay at their reset value. Word index 1 reads the stored mask ANDed with 0xF05DFF80.
- R4: Source lines map to levels as follows. Lines 0–6 and lines 7–13 each map to 2, 3, 5, 7, 9, 11, 13 in turn. Lines 14 and 15 map to 12. Line 16 maps to 6, 17 to 13, 18 to 4, 19 to 10, 20 to 8, 21 to 9 and 22 to 11. Lines 27–30 map to 15. All other lines map to 0, which means unused.
- R5: The target processor's level vector has bit L set exactly when some pending, unmasked source maps to level L. Every other processor's level vector is zero.
- R6: When mask bit 31 is set, `master_off_o` is 1 and every level vector is zero.
- R7: Setting a mask bit never clears the matching pending bit.
- R8: A write to word index 4 stores the low log2(NUM_CPUS) bits of the write data as the target. Word index 4 reads the target back zero-extended.
- R9: The target processor's status vector has bit L set for each pending source at level L, regardless of the mask. Other processors get zero.
- R10: Writes to word indices 0, 1, 5, 6 and 7 change nothing. Reads of word indices 2, 3, 5, 6 and 7 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | 32 | Level-sensitive hardware interrupt lines |
| bus_we_i | input | 1 | Write strobe for the register port |
| bus_addr_i | input | 3 | Word index of the access |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for the addressed word |
| cpu_level_o | output | NUM_CPUS*16 | Per-processor hard level vectors, processor c in bits c*16 +: 16 |
| cpu_status_o | output | NUM_CPUS*16 | Per-processor status vectors, same layout |
| master_off_o | output | 1 | Global disable currently set |

## Verification
The assertions assume that reset is held low for at least one clock edge and that the write strobe and the word index are stable around each rising edge. The bench drives every input on the falling edge, so both conditions always hold.

The assertion on target writes compares against the write data of the previous cycle. The bench never writes the target on two consecutive edges without idling between them. The bench sweeps every single source line across every processor as target, then applies multi-line patterns with assorted mask settings, so all level entries and both edges of the mask switch are exercised.

// File: rtl/irq_router.sv
module irq_router #(
  parameter int NUM_CPUS = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [31:0]            src_i,
  input  logic                   bus_we_i,
  input  logic [2:0]             bus_addr_i,
  input  logic [31:0]            bus_wdata_i,
  output logic [31:0]            bus_rdata_o,
  output logic [NUM_CPUS*16-1:0] cpu_level_o,
  output logic [NUM_CPUS*16-1:0] cpu_status_o,
  output logic                   master_off_o
);

  localparam int          TW        = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1;
  localparam logic [31:0] IMPL_BITS = 32'hF05DFF80;
  localparam logic [31:0] MASK_RST  = ~IMPL_BITS;

  function automatic logic [3:0] src_level(input int b);
    case (b)
      0, 7:            return 4'd2;
      1, 8:            return 4'd3;
      2, 9:            return 4'd5;
      3, 10:           return 4'd7;
      4, 11, 21:       return 4'd9;
      5, 12, 22:       return 4'd11;
      6, 13, 17:       return 4'd13;
      14, 15:          return 4'd12;
      16:              return 4'd6;
      18:              return 4'd4;
      19:              return 4'd10;
      20:              return 4'd8;
      27, 28, 29, 30:  return 4'd15;
      default:         return 4'd0;
    endcase
  endfunction

  function automatic logic [31:0] live_lines();
    logic [31:0] m;
    m = '0;
    for (int b = 0; b < 32; b++) m[b] = (src_level(b) != 4'd0);
    return m;
  endfunction

  localparam logic [31:0] LIVE = live_lines();

  logic [31:0]   pend_q, mask_q;
  logic [TW-1:0] tgt_q;
  logic [15:0]   hard_vec, stat_vec;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      mask_q <= MASK_RST;
      tgt_q  <= '0;
    end else begin
      pend_q <= src_i & LIVE;
      if (bus_we_i) begin
        case (bus_addr_i)
          3'd2: mask_q <= mask_q & ~(bus_wdata_i & IMPL_BITS);
          3'd3: mask_q <= mask_q | (bus_wdata_i & IMPL_BITS);
          3'd4: tgt_q  <= bus_wdata_i[TW-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    hard_vec = '0;
    stat_vec = '0;
    for (int b = 0; b < 32; b++) begin
      if (src_level(b) != 4'd0) begin
        if (pend_q[b])
          stat_vec = stat_vec | (16'd1 << src_level(b));
        if (pend_q[b] && !mask_q[b])
          hard_vec = hard_vec | (16'd1 << src_level(b));
      end
    end
  end

  always_comb begin
    case (bus_addr_i)
      3'd0:    bus_rdata_o = {1'b0, pend_q[30:0]};
      3'd1:    bus_rdata_o = mask_q & IMPL_BITS;
      3'd4:    bus_rdata_o = 32'(tgt_q);
      default: bus_rdata_o = '0;
    endcase
  end

  assign master_off_o = mask_q[31];

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    logic sel;
    assign sel = (32'(tgt_q) == c);
    assign cpu_level_o[c*16 +: 16]  = (sel && !mask_q[31]) ? hard_vec : 16'd0;
    assign cpu_status_o[c*16 +: 16] = sel ? stat_vec : 16'd0;
  end

endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
  parameter int NUM_CPUS = 4,
  parameter int TW       = 2
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   bus_we_i,
  input logic [2:0]             bus_addr_i,
  input logic [31:0]            bus_wdata_i,
  input logic [NUM_CPUS*16-1:0] cpu_level_o,
  input logic [NUM_CPUS*16-1:0] cpu_status_o,
  input logic                   master_off_o,
  input logic [31:0]            pend_q,
  input logic [31:0]            mask_q,
  input logic [TW-1:0]          tgt_q
);

  logic [NUM_CPUS-1:0] lvl_any, stat_any;
  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_any
    assign lvl_any[c]  = |cpu_level_o[c*16 +: 16];
    assign stat_any[c] = |cpu_status_o[c*16 +: 16];
  end

  AST_MASTER_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    master_off_o |-> (cpu_level_o == '0));                            // R6
  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lvl_any));                                               // R5
  AST_STATUS_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(stat_any));                                              // R9
  AST_SPARE_MASK_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q & 32'h0FA2007F) == 32'h0FA2007F);                         // R3
  AST_TARGET_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we_i && bus_addr_i == 3'd4) |=> (tgt_q == $past(bus_wdata_i[TW-1:0]))); // R8
  AST_LEVEL_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_any != '0) |-> (pend_q != '0));                              // R7
  AST_LEVEL_ZERO_UNUSED: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q[31] == 1'b0) && (pend_q[26:23] == 4'd0));                 // R2

endmodule

bind irq_router irq_router_chk #(.NUM_CPUS(NUM_CPUS), .TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we_i(bus_we_i), .bus_addr_i(bus_addr_i),
  .bus_wdata_i(bus_wdata_i), .cpu_level_o(cpu_level_o),
  .cpu_status_o(cpu_status_o), .master_off_o(master_off_o),
  .pend_q(pend_q), .mask_q(mask_q), .tgt_q(tgt_q)
);

// File: tb/test_irq_router.sv
module test_irq_router;
  localparam int NC = 4;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [31:0]    src = '0;
  logic           we = 1'b0;
  logic [2:0]     addr = '0;
  logic [31:0]    wdata = '0;
  logic [31:0]    rdata;
  logic [NC*16-1:0] lvl, stat;
  logic           moff;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] pend_m = '0, mask_m = 32'h0FA2007F;
  int tgt_m = 0;

  irq_router #(.NUM_CPUS(NC)) i_irq_router (
    .clk(clk), .rst_n(rst_n), .src_i(src), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .cpu_level_o(lvl),
    .cpu_status_o(stat), .master_off_o(moff));

  always #5 clk = ~clk;

  function automatic int lv(input int b);
    int t[32] = '{2,3,5,7,9,11,13,2,3,5,7,9,11,13,12,12,
                  6,13,4,10,8,9,11,0,0,0,0,15,15,15,15,0};
    return t[b];
  endfunction

  function automatic logic [15:0] exp_vec(input int c, input bit hard);
    logic [15:0] v = '0;
    if (c != tgt_m) return '0;
    if (hard && mask_m[31]) return '0;
    for (int b = 0; b < 32; b++)
      if (pend_m[b] && lv(b) != 0 && (!hard || !mask_m[b])) v[lv(b)] = 1'b1;
    return v;
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    addr = 3'(a);
    #1 d = rdata;
  endtask

  task automatic check_all(input string tag);
    logic [31:0] d;
    rd(0, d); chk({tag, " pending"}, d, pend_m & 32'h7FFFFFFF);
    rd(1, d); chk({tag, " mask"}, d, mask_m & 32'hF05DFF80);
    rd(4, d); chk({tag, " target"}, d, 32'(tgt_m));
    chk({tag, " master"}, 32'(moff), 32'(mask_m[31]));
    for (int c = 0; c < NC; c++) begin
      chk({tag, " level"}, 32'(lvl[c*16 +: 16]), 32'(exp_vec(c, 1)));
      chk({tag, " status"}, 32'(stat[c*16 +: 16]), 32'(exp_vec(c, 0)));
    end
  endtask

  task automatic drive_src(input logic [31:0] s);
    @(negedge clk);
    src = s;
    @(negedge clk);
    pend_m = s & 32'h787FFFFF;
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = 3'(a); wdata = d;
    @(negedge clk);
    we = 1'b0;
    case (a)
      2: mask_m = mask_m & ~(d & 32'hF05DFF80);
      3: mask_m = mask_m | (d & 32'hF05DFF80);
      4: tgt_m = int'(d[1:0]);
      default: ;
    endcase
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [31:0] pats[6] = '{32'hFFFFFFFF, 32'hA5A5A5A5, 32'h5A5A5A5A,
                             32'h0000C000, 32'h78000000, 32'h00400001};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1");

    // R4 R5 R2: each line alone, each processor as target
    for (int t = 0; t < NC; t++) begin
      wr(4, 32'(t));
      for (int b = 0; b < 32; b++) begin
        drive_src(32'd1 << b);
        check_all("R4");
      end
    end

    // R7 R3: mask each line, pending must survive
    wr(4, 32'd2);
    for (int b = 0; b < 32; b++) begin
      drive_src(32'd1 << b);
      wr(3, 32'd1 << b);
      check_all("R7");
      wr(2, 32'hFFFFFFFF);
      check_all("R3");
    end

    // R5 R9: combined patterns with mixed masks
    foreach (pats[i]) begin
      drive_src(pats[i]);
      wr(4, 32'(i + 5));
      check_all("R8");
      wr(3, 32'h00F0F000);
      check_all("R9");
      wr(2, 32'h00F0F000);
      check_all("R5");
    end

    // R6: master off and back on
    drive_src(32'h7FFFFFFF);
    wr(3, 32'h80000000);
    check_all("R6");
    wr(2, 32'h80000000);
    check_all("R6");

    // R10: ignored writes, zero reads
    wr(3, 32'h00001000);
    foreach (pats[i]) begin
      wr(0, 32'hFFFFFFFF);
      wr(1, 32'hFFFFFFFF);
      wr(5 + (i % 3), 32'hFFFFFFFF);
      check_all("R10");
    end
    for (int a = 2; a < 8; a++) begin
      if (a == 4) continue;
      rd(a, d);
      chk("R10 unused read", d, 32'd0);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule